// File: doc/BRIEF.md
# On-Screen-Display Write-Format Decoder

This block sits after a serial byte receiver and turns a stream of whole bytes into single writes for an on-screen-display memory. That memory holds a character code plane and a character attribute plane. Each incoming byte is classed by its two top bits and by the decoder's current phase, which gives a row-address byte, a column-address byte or a data byte. Three write formats share one grammar. Format (a) sends a row, then a column, then one data byte. Format (b) sends a new column and one data byte on the row already given. Format (c) sends a burst of data bytes, and the address steps forward by itself after each one.

Output writes leave through a valid/ready pair. `wr_ready` is the grant from the display-timing arbiter: it is high only when the memory is free of display fetches. A decoded write stays on the output, unchanged, until it is granted. The input side has no back-pressure, because the serial receiver cannot stall. A data byte that arrives while a write is still waiting, and is not granted in that same cycle, is dropped, and `overflow` pulses for one cycle. A `frame_start` pulse restarts the decoder and discards any waiting write.

Top module: `osd_write_decoder`

## Requirements
- R1: After reset, `wr_valid` and `overflow` are 0 and the decoder is waiting for a row byte.
- R2: While waiting for a row, bytes with bit 7 = 0 cause no write. A byte with bit 7 = 1 is taken as a row byte: bit 6 = 1 selects the attribute plane (`wr_attr` = 1) and bit 6 = 0 selects the code plane, bits 3..0 give the row, and bits 5..4 have no effect.
- R3: After a row, a byte with bit 7 = 0 is a column byte and bits 4..0 give the column. If its bit 6 = 0, exactly the next byte, whatever its value, is data for one write at that row and column.
- R4: After a single data byte, the next byte is decoded by bits 7..6. The value 1x is a new row (format a), 00 is a new column on the same row and plane (format b), and 01 is a burst column.
- R5: Consecutive row bytes are allowed, and the last one received sets the row and the plane.
- R6: In burst mode every byte is data. The first write goes to the column byte's address. After each accepted write the column increases by 1. Column 31 wraps to 0 and the row increases by 1, and row 15 wraps to 0.
- R7: Burst mode ends only on `frame_start` or reset. Bytes with bit 7 = 1 are written as data while in burst mode.
- R8: `wr_valid` rises in the cycle after the data byte is sampled. While `wr_ready` is 0, `wr_valid`, `wr_attr`, `wr_row`, `wr_col` and `wr_data` stay stable. `wr_valid` falls after a grant cycle unless a new write is accepted in that same cycle.
- R9: A data byte that arrives while `wr_valid` = 1 and `wr_ready` = 0 is dropped. `overflow` is 1 for the following cycle only. The waiting write is kept, and the burst address does not advance.
- R10: `frame_start` clears any waiting write in the next cycle and returns the decoder to waiting for a row. A byte sampled in the same cycle as `frame_start` is ignored.
- R11: A data byte that arrives in the same cycle as a grant is accepted, and its write appears in the next cycle with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle pulse at the start of a serial frame |
| byte_valid | input | 1 | `byte_data` holds a received byte this cycle |
| byte_data | input | 8 | Received byte |
| wr_ready | input | 1 | Memory access grant from display timing |
| wr_valid | output | 1 | A write is pending |
| wr_attr | output | 1 | 1 = attribute plane, 0 = code plane |
| wr_row | output | 4 | Write row |
| wr_col | output | 5 | Write column |
| wr_data | output | 8 | Write data |
| overflow | output | 1 | One-cycle pulse: a data byte was dropped |

## Verification
The assertions assume that every input is sampled synchronously and is free of unknowns once reset is released. `frame_start` may coincide with `byte_valid`, and `wr_ready` may take any value in any cycle, including while no write is pending. The stimulus changes inputs only on the falling edge. It holds `frame_start` and `byte_valid` for a single cycle, and it uses `wr_ready` both to leave a write waiting and to grant it in the same cycle as a new byte, so the hold, drop and same-cycle acceptance paths are all reached.

// File: rtl/osd_dec_pkg.sv
package osd_dec_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_DATA  = 2'd2,
    ST_BURST = 2'd3
  } dec_state_e;

  function automatic logic top_is_row(input logic [1:0] top);
    return top[1];
  endfunction

  function automatic logic col_is_burst(input logic [1:0] top);
    return top[0];
  endfunction

endpackage

// File: rtl/osd_fmt_fsm.sv
module osd_fmt_fsm
  import osd_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic       byte_valid,
  input  logic [1:0] byte_top,
  input  logic       slot_free,
  output logic       ld_row,
  output logic       ld_col,
  output logic       issue,
  output logic       burst_mode,
  output logic       overflow
);

  dec_state_e state_q, state_d;
  logic       drop;

  always_comb begin
    state_d = state_q;
    ld_row  = 1'b0;
    ld_col  = 1'b0;
    issue   = 1'b0;
    drop    = 1'b0;
    if (byte_valid && !frame_start) begin
      unique case (state_q)
        ST_IDLE: begin
          if (top_is_row(byte_top)) begin
            ld_row  = 1'b1;
            state_d = ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (top_is_row(byte_top)) begin
            ld_row = 1'b1;
          end else begin
            ld_col  = 1'b1;
            state_d = col_is_burst(byte_top) ? ST_BURST : ST_DATA;
          end
        end
        ST_DATA: begin
          if (slot_free) begin
            issue   = 1'b1;
            state_d = ST_ADDR;
          end else begin
            drop = 1'b1;
          end
        end
        ST_BURST: begin
          if (slot_free) issue = 1'b1;
          else           drop  = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      state_q  <= ST_IDLE;
      overflow <= 1'b0;
    end else begin
      state_q  <= state_d;
      overflow <= drop;
    end
  end

  assign burst_mode = (state_q == ST_BURST);

  AST_BURST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BURST && !frame_start) |=> (state_q == ST_BURST)); // R7

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !issue); // R2

endmodule

// File: rtl/osd_addr_gen.sv
module osd_addr_gen #(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned COL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_row,
  input  logic             ld_col,
  input  logic             step,
  input  logic             attr_in,
  input  logic [ROW_W-1:0] row_in,
  input  logic [COL_W-1:0] col_in,
  output logic             attr,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);

  localparam logic [COL_W-1:0] COL_LAST = {COL_W{1'b1}};
  localparam logic [ROW_W-1:0] ROW_ONE  = {{(ROW_W-1){1'b0}}, 1'b1};
  localparam logic [COL_W-1:0] COL_ONE  = {{(COL_W-1){1'b0}}, 1'b1};

  logic col_at_end;
  assign col_at_end = (col == COL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      attr <= 1'b0;
      row  <= '0;
      col  <= '0;
    end else if (ld_row) begin
      attr <= attr_in;
      row  <= row_in;
    end else if (ld_col) begin
      col <= col_in;
    end else if (step) begin
      col <= col + COL_ONE;
      if (col_at_end) row <= row + ROW_ONE;
    end
  end

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && col_at_end) |=> (col == '0 && row == ROW_W'($past(row) + ROW_ONE))); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !col_at_end) |=> (col == COL_W'($past(col) + COL_ONE) && $stable(row))); // R6

endmodule

// File: rtl/osd_wr_slot.sv
module osd_wr_slot #(
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              load,
  input  logic              attr_in,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [COL_W-1:0]  col_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              wr_ready,
  output logic              slot_free,
  output logic              wr_valid,
  output logic              wr_attr,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_data
);

  assign slot_free = !wr_valid || wr_ready;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_valid <= 1'b0;
    end else if (load) begin
      wr_valid <= 1'b1;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_attr <= 1'b0;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_data <= '0;
    end else if (load) begin
      wr_attr <= attr_in;
      wr_row  <= row_in;
      wr_col  <= col_in;
      wr_data <= data_in;
    end
  end

  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready && !flush) |=> (wr_valid && $stable(wr_data) && $stable(wr_row) && $stable(wr_col) && $stable(wr_attr))); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> !wr_valid); // R10

endmodule

// File: rtl/osd_write_decoder.sv
module osd_write_decoder
  import osd_dec_pkg::*;
#(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned COL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic              wr_attr,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [BYTE_W-1:0] wr_data,
  output logic              overflow
);

  localparam int unsigned ATTR_BIT = 6;

  logic             ld_row, ld_col, issue, burst_mode, slot_free;
  logic             cur_attr;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;

  osd_fmt_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .byte_valid (byte_valid),
    .byte_top   (byte_data[BYTE_W-1 -: 2]),
    .slot_free  (slot_free),
    .ld_row     (ld_row),
    .ld_col     (ld_col),
    .issue      (issue),
    .burst_mode (burst_mode),
    .overflow   (overflow)
  );

  osd_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .ld_row (ld_row),
    .ld_col (ld_col),
    .step   (issue && burst_mode),
    .attr_in(byte_data[ATTR_BIT]),
    .row_in (byte_data[ROW_W-1:0]),
    .col_in (byte_data[COL_W-1:0]),
    .attr   (cur_attr),
    .row    (cur_row),
    .col    (cur_col)
  );

  osd_wr_slot #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(BYTE_W)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .flush    (frame_start),
    .load     (issue),
    .attr_in  (cur_attr),
    .row_in   (cur_row),
    .col_in   (cur_col),
    .data_in  (byte_data),
    .wr_ready (wr_ready),
    .slot_free(slot_free),
    .wr_valid (wr_valid),
    .wr_attr  (wr_attr),
    .wr_row   (wr_row),
    .wr_col   (wr_col),
    .wr_data  (wr_data)
  );

  AST_DROP_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(wr_valid && !wr_ready)); // R9

  AST_OVF_KEEPS_WRITE: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (wr_valid && $stable(wr_data))); // R9

  AST_NO_WRITE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!wr_valid && !overflow)); // R1

endmodule

// File: tb/osd_write_decoder_tb_top.sv
module osd_write_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       wr_ready = 1'b0;
  logic       wr_valid, wr_attr, overflow;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [7:0] wr_data;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  osd_write_decoder dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .byte_valid(byte_valid), .byte_data(byte_data), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_attr(wr_attr), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data), .overflow(overflow)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic peek(input string req, input logic a, input logic [3:0] r, input logic [4:0] c, input logic [7:0] d);
    chk(req, "wr_valid", {31'd0, wr_valid}, 32'd1);
    chk(req, "attr/row/col/data", {14'd0, wr_attr, wr_row, wr_col, wr_data}, {14'd0, a, r, c, d});
  endtask

  task automatic expect_wr(input string req, input logic a, input logic [3:0] r, input logic [4:0] c, input logic [7:0] d);
    peek(req, a, r, c, d);
    repeat (2) @(negedge clk);
    chk("R8", "held payload", {14'd0, wr_valid, wr_attr, wr_row, wr_col, wr_data}, {14'd0, 1'b1, a, r, c, d});
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    chk("R8", "valid after grant", {31'd0, wr_valid}, 32'd0);
  endtask

  task automatic expect_none(input string req);
    chk(req, "no write", {31'd0, wr_valid}, 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "wr_valid", {31'd0, wr_valid}, 32'd0);
    chk("R1", "overflow", {31'd0, overflow}, 32'd0);
  endtask

  task automatic t_format_a();
    pulse_frame();
    send(8'h05);
    send(8'h12);
    expect_none("R2");
    send(8'hB3);
    expect_none("R2");
    send(8'h07);
    send(8'h9C);
    expect_wr("R3", 1'b0, 4'd3, 5'd7, 8'h9C);
  endtask

  task automatic t_format_b_then_a();
    send(8'h0A);
    send(8'h41);
    expect_wr("R4", 1'b0, 4'd3, 5'd10, 8'h41);
    send(8'hC5);
    send(8'h01);
    send(8'h00);
    expect_wr("R4", 1'b1, 4'd5, 5'd1, 8'h00);
  endtask

  task automatic t_row_repeat();
    pulse_frame();
    send(8'h81);
    send(8'hC2);
    send(8'h8E);
    send(8'h02);
    send(8'h55);
    expect_wr("R5", 1'b0, 4'd14, 5'd2, 8'h55);
  endtask

  task automatic t_burst_row_wrap();
    pulse_frame();
    send(8'hCF);
    send(8'h5E);
    send(8'h11);
    expect_wr("R6", 1'b1, 4'd15, 5'd30, 8'h11);
    send(8'h92);
    expect_wr("R7", 1'b1, 4'd15, 5'd31, 8'h92);
    send(8'hC3);
    expect_wr("R6", 1'b1, 4'd0, 5'd0, 8'hC3);
    send(8'h40);
    expect_wr("R7", 1'b1, 4'd0, 5'd1, 8'h40);
  endtask

  task automatic t_burst_col_wrap();
    pulse_frame();
    send(8'h82);
    send(8'h5F);
    send(8'h21);
    expect_wr("R6", 1'b0, 4'd2, 5'd31, 8'h21);
    send(8'h22);
    expect_wr("R6", 1'b0, 4'd3, 5'd0, 8'h22);
  endtask

  task automatic t_overflow_and_same_cycle();
    pulse_frame();
    send(8'h81);
    send(8'h43);
    send(8'hA0);
    send(8'hA1);
    chk("R9", "overflow pulse", {31'd0, overflow}, 32'd1);
    peek("R9", 1'b0, 4'd1, 5'd3, 8'hA0);
    @(negedge clk);
    chk("R9", "overflow one cycle", {31'd0, overflow}, 32'd0);
    expect_wr("R9", 1'b0, 4'd1, 5'd3, 8'hA0);
    send(8'hA2);
    peek("R9", 1'b0, 4'd1, 5'd4, 8'hA2);
    @(negedge clk);
    wr_ready   = 1'b1;
    byte_valid = 1'b1;
    byte_data  = 8'hA3;
    @(negedge clk);
    wr_ready   = 1'b0;
    byte_valid = 1'b0;
    chk("R11", "overflow", {31'd0, overflow}, 32'd0);
    expect_wr("R11", 1'b0, 4'd1, 5'd5, 8'hA3);
  endtask

  task automatic t_frame_flush();
    send(8'hA4);
    chk("R10", "pending before flush", {31'd0, wr_valid}, 32'd1);
    @(negedge clk);
    frame_start = 1'b1;
    byte_valid  = 1'b1;
    byte_data   = 8'h85;
    @(negedge clk);
    frame_start = 1'b0;
    byte_valid  = 1'b0;
    expect_none("R10");
    send(8'h01);
    send(8'h33);
    expect_none("R10");
    send(8'h81);
    send(8'h02);
    send(8'h44);
    expect_wr("R7", 1'b0, 4'd1, 5'd2, 8'h44);
    send(8'h03);
    send(8'h45);
    expect_wr("R4", 1'b0, 4'd1, 5'd3, 8'h45);
  endtask

  initial begin
    t_reset();
    t_format_a();
    t_format_b_then_a();
    t_row_repeat();
    t_burst_row_wrap();
    t_burst_col_wrap();
    t_overflow_and_same_cycle();
    t_frame_flush();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule